// File: doc/BRIEF.md
# Selective Per-Row DRAM Refresh Controller

This controller decides when each DRAM row gets a refresh command. It does not sweep the whole array at one fixed rate. Instead it tracks, for every row, whether the row holds live data and how long that row can retain it. Rows with no live data are never refreshed. Each live row is refreshed on its own cadence, which is a multiple of a base refresh tick.

A granted write marks its row live and stores a 2-bit retention code for it. A separate invalidate input marks a row dead. On every base tick, each live row counts down. A row whose count runs out raises a pending flag and reloads its count. A round-robin picker turns pending rows into refresh commands, one at a time. The same arbiter serves read and write requests through a request/grant handshake. While a refresh is running, accesses are held off.

A compatibility input forces every row to be treated as live with one common code. This gives the conventional sweep-all behaviour for comparison. A saturating count of issued refreshes is exported for energy bookkeeping.

Top module: `sel_refresh_ctl`

## Requirements
- R1: After reset, `ref_cmd`, `acc_gnt` and `ref_count` are all zero.
- R2: With `legacy` low, a row that is not live is never refreshed. A granted read (`acc_we`=0) does not make a row live.
- R3: A granted write to row r makes r live, stores `acc_code` as its code, and loads its countdown with 2^code ticks (code 0,1,2,3 gives 1,2,4,8 ticks). Row r then becomes due on every tick whose index since the write is a multiple of 2^code.
- R4: Asserting `inv` makes row `inv_row` not live in that cycle and drops any refresh already pending for it. That pending refresh is never issued.
- R5: With `legacy` high, every row counts and becomes due as if it were live with code `LEG_CODE`. Counters cleared by reset make every row due on the first tick.
- R6: At most one refresh is issued at a time. `ref_cmd` is a one-cycle pulse with `ref_row`. Pending rows are served round-robin, starting at the row just after the last one refreshed.
- R7: When the arbiter is idle and nothing is pending, a request is granted with a one-cycle `acc_gnt` pulse at the next clock edge. An access occupies `ACC_CYCLES` cycles and a refresh occupies `REF_CYCLES` cycles. No grant is issued inside either window.
- R8: A refresh that becomes due during an access is issued at the edge that ends that access. It goes ahead of any request waiting at that edge.
- R9: `ref_count` increments with each issued refresh and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base refresh interval strobe, one cycle |
| legacy | input | 1 | Treat all rows as live with common code |
| acc_req | input | 1 | Access request, held until granted |
| acc_we | input | 1 | Access is a write |
| acc_row | input | $clog2(ROWS) | Row addressed by the access |
| acc_code | input | 2 | Retention code stored by a write |
| inv | input | 1 | Invalidate strobe |
| inv_row | input | $clog2(ROWS) | Row to invalidate |
| acc_gnt | output | 1 | Grant pulse |
| ref_cmd | output | 1 | Refresh command pulse |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| ref_count | output | RCNT_W | Saturating refresh count |

## Verification
The bench builds the block with eight rows, three-cycle refresh and access windows, a common code of 1, and a 4-bit refresh counter.

With only eight rows, every row can be swept against a retention code, and each of the four codes appears twice over eight ticks. The short counter reaches saturation within three compatibility-mode bursts. The short windows make the stall and priority latencies small, exact numbers of edges, which the bench checks directly.

// File: rtl/sel_refresh_ctl.sv
module sel_refresh_ctl #(
  parameter int ROWS = 16,
  parameter int REF_CYCLES = 4,
  parameter int ACC_CYCLES = 2,
  parameter int RCNT_W = 16,
  parameter logic [1:0] LEG_CODE = 2'd2,
  localparam int RW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              legacy,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [RW-1:0]     acc_row,
  input  logic [1:0]        acc_code,
  input  logic              inv,
  input  logic [RW-1:0]     inv_row,
  output logic              acc_gnt,
  output logic              ref_cmd,
  output logic [RW-1:0]     ref_row,
  output logic [RCNT_W-1:0] ref_count
);

  localparam int BMAX = (REF_CYCLES > ACC_CYCLES) ? REF_CYCLES : ACC_CYCLES;
  localparam int BW = $clog2(BMAX + 1);

  logic [ROWS-1:0] valid_q, pend_q, elig, counting, expire, inv_hit;
  logic [1:0]      code_q [ROWS];
  logic [3:0]      cnt_q  [ROWS];
  logic [BW-1:0]   bcnt_q;
  logic [RW-1:0]   rr_q, pick;
  logic            any, free, issue, wr_go;

  assign free  = bcnt_q <= BW'(1);
  assign issue = free && any;
  assign wr_go = free && !any && acc_req && acc_we;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      counting[r] = legacy || valid_q[r];
      inv_hit[r]  = inv && (inv_row == RW'(r));
      expire[r]   = tick && counting[r] && (cnt_q[r] <= 4'd1);
      elig[r]     = pend_q[r] && counting[r] && !inv_hit[r];
    end
  end

  always_comb begin
    logic [RW-1:0] idx;
    any  = 1'b0;
    pick = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      idx = rr_q + RW'(i);
      if (elig[idx]) begin
        any  = 1'b1;
        pick = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt_q    <= '0;
      rr_q      <= '0;
      ref_cmd   <= 1'b0;
      ref_row   <= '0;
      acc_gnt   <= 1'b0;
      ref_count <= '0;
      valid_q   <= '0;
      pend_q    <= '0;
      for (int r = 0; r < ROWS; r++) begin
        code_q[r] <= 2'd0;
        cnt_q[r]  <= 4'd0;
      end
    end else begin
      ref_cmd <= 1'b0;
      acc_gnt <= 1'b0;
      if (!free) begin
        bcnt_q <= bcnt_q - BW'(1);
      end else if (any) begin
        bcnt_q  <= BW'(REF_CYCLES);
        ref_cmd <= 1'b1;
        ref_row <= pick;
        rr_q    <= pick + RW'(1);
        if (ref_count != '1) ref_count <= ref_count + RCNT_W'(1);
      end else if (acc_req) begin
        bcnt_q  <= BW'(ACC_CYCLES);
        acc_gnt <= 1'b1;
      end else begin
        bcnt_q <= '0;
      end

      for (int r = 0; r < ROWS; r++) begin
        if (inv_hit[r]) begin
          valid_q[r] <= 1'b0;
          pend_q[r]  <= 1'b0;
        end else if (wr_go && acc_row == RW'(r)) begin
          valid_q[r] <= 1'b1;
          code_q[r]  <= acc_code;
          cnt_q[r]   <= 4'd1 << acc_code;
          pend_q[r]  <= 1'b0;
        end else begin
          if (tick && counting[r])
            cnt_q[r] <= expire[r] ? (4'd1 << (legacy ? LEG_CODE : code_q[r]))
                                  : cnt_q[r] - 4'd1;
          if (expire[r])
            pend_q[r] <= 1'b1;
          else if ((issue && pick == RW'(r)) || !counting[r])
            pend_q[r] <= 1'b0;
        end
      end
    end
  end

endmodule

module sel_refresh_ctl_chk #(
  parameter int ROWS = 16,
  parameter int RCNT_W = 16,
  parameter int REF_CYCLES = 4,
  localparam int RW = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_gnt,
  input logic              ref_cmd,
  input logic              legacy,
  input logic [RW-1:0]     ref_row,
  input logic [RCNT_W-1:0] ref_count,
  input logic [ROWS-1:0]   row_valid
);

  p_only_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> ($past(legacy) || row_valid[ref_row]));

  p_no_gnt_with_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_cmd && acc_gnt));

  p_gnt_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> $past(acc_req));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> (ref_count == $past(ref_count) + RCNT_W'(1) || ref_count == '1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_cmd |-> $stable(ref_count));

  if (REF_CYCLES > 1) begin : g_gap
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |=> (!ref_cmd && !acc_gnt));
  end

endmodule

bind sel_refresh_ctl sel_refresh_ctl_chk #(
  .ROWS(ROWS), .RCNT_W(RCNT_W), .REF_CYCLES(REF_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
  .ref_cmd(ref_cmd), .legacy(legacy), .ref_row(ref_row),
  .ref_count(ref_count), .row_valid(valid_q)
);

// File: tb/test_sel_refresh_ctl.sv
module test_sel_refresh_ctl;
  localparam int ROWS = 8;
  localparam int RW = 3;
  localparam int RC = 3;
  localparam int AC = 3;

  logic clk = 0, rst_n = 0, tick = 0, legacy = 0;
  logic acc_req = 0, acc_we = 0, inv = 0;
  logic [RW-1:0] acc_row = '0, inv_row = '0;
  logic [1:0] acc_code = '0;
  logic acc_gnt, ref_cmd;
  logic [RW-1:0] ref_row;
  logic [3:0] ref_count;

  int nchk = 0, nerr = 0, nref = 0;
  int seq [8];

  always #10 clk = ~clk;

  sel_refresh_ctl #(.ROWS(ROWS), .REF_CYCLES(RC), .ACC_CYCLES(AC),
                    .RCNT_W(4), .LEG_CODE(2'd1)) i_sel_refresh_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .legacy(legacy),
    .acc_req(acc_req), .acc_we(acc_we), .acc_row(acc_row), .acc_code(acc_code),
    .inv(inv), .inv_row(inv_row), .acc_gnt(acc_gnt), .ref_cmd(ref_cmd),
    .ref_row(ref_row), .ref_count(ref_count));

  always @(negedge clk) if (ref_cmd) begin
    if (nref < 8) seq[nref] = int'(ref_row);
    nref++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk); #2;
  endtask

  task automatic do_tick;
    tick = 1; cyc; tick = 0; nref = 0;
    repeat (40) cyc;
  endtask

  task automatic access(input bit we, input int row, input int code);
    acc_req = 1; acc_we = we; acc_row = RW'(row); acc_code = 2'(code);
    do cyc; while (!acc_gnt);
    acc_req = 0; acc_we = 0;
    repeat (AC + 1) cyc;
  endtask

  task automatic kill(input int row);
    inv = 1; inv_row = RW'(row); cyc; inv = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n, m, mref, mg;
    repeat (4) cyc;
    rst_n = 1; cyc;
    check(ref_cmd == 0, "R1 ref_cmd", int'(ref_cmd), 0);
    check(acc_gnt == 0, "R1 acc_gnt", int'(acc_gnt), 0);
    check(ref_count == 0, "R1 ref_count", int'(ref_count), 0);

    // R5 compatibility mode: code 1 means period 2, reset counters due at first tick
    legacy = 1; cyc;
    for (int k = 1; k <= 5; k++) begin
      do_tick;
      check(nref == ((k % 2) ? 8 : 0), "R5 legacy burst size", nref, (k % 2) ? 8 : 0);
      if (k == 1) begin
        for (int i = 0; i < 8; i++) check(seq[i] == i, "R6 round-robin order", seq[i], i);
        check(ref_count == 8, "R9 count", int'(ref_count), 8);
      end
    end
    check(ref_count == 15, "R9 saturation", int'(ref_count), 15);
    legacy = 0; cyc;

    // R2: no live rows, and a read does not make a row live
    access(0, 5, 0);
    for (int k = 1; k <= 8; k++) begin
      do_tick;
      check(nref == 0, "R2 dead row refreshed", nref, 0);
    end

    // R3 sweep over rows and codes
    for (int r = 0; r < 8; r++) begin
      access(1, r, r % 4);
      for (int k = 1; k <= 8; k++) begin
        do_tick;
        n = ((k % (1 << (r % 4))) == 0) ? 1 : 0;
        check(nref == n, "R3 due cadence", nref, n);
        if (n == 1) check(seq[0] == r, "R3 refreshed row", seq[0], r);
      end
      kill(r);
    end

    // R4: invalidate stops further refreshes
    access(1, 2, 0);
    do_tick;
    check(nref == 1 && seq[0] == 2, "R4 before invalidate", nref, 1);
    kill(2);
    for (int k = 0; k < 3; k++) begin
      do_tick;
      check(nref == 0, "R4 after invalidate", nref, 0);
    end

    // R6: pointer at row 3 now, so row 6 goes before row 1
    access(1, 1, 0);
    access(1, 6, 0);
    do_tick;
    check(nref == 2, "R6 two refreshes", nref, 2);
    check(seq[0] == 6, "R6 first after pointer", seq[0], 6);
    check(seq[1] == 1, "R6 wrap", seq[1], 1);
    kill(1); kill(6);

    // R4: a pending refresh is dropped by invalidate
    access(1, 3, 0); access(1, 4, 0); access(1, 5, 0);
    tick = 1; cyc; tick = 0; nref = 0;
    cyc;
    inv = 1; inv_row = 3'd5; cyc; inv = 0;
    repeat (30) cyc;
    check(nref == 2, "R4 pending dropped", nref, 2);
    check(seq[0] == 3 && seq[1] == 4, "R4 survivors order", seq[1], 4);
    kill(3); kill(4);

    // R7: idle grant after one edge
    acc_req = 1; n = 0;
    do begin cyc; n++; end while (!acc_gnt && n < 50);
    acc_req = 0;
    check(n == 1, "R7 idle grant latency", n, 1);
    repeat (10) cyc;

    // R7: access stalled behind refresh
    access(1, 0, 0);
    tick = 1; cyc; tick = 0; nref = 0;
    acc_req = 1; n = 0;
    do begin cyc; n++; end while (!acc_gnt && n < 50);
    acc_req = 0;
    check(n == RC + 1, "R7 stall behind refresh", n, RC + 1);
    check(nref == 1, "R7 refresh went first", nref, 1);
    repeat (10) cyc;

    // R8: refresh due during access waits for it, then beats the waiting request
    acc_req = 1;
    do cyc; while (!acc_gnt);
    tick = 1; m = 0; mref = 0; mg = 0;
    do begin
      cyc; m++; tick = 0;
      if (ref_cmd && mref == 0) mref = m;
      if (acc_gnt) mg = m;
    end while (mg == 0 && m < 50);
    acc_req = 0;
    check(mref == AC, "R8 refresh at access end", mref, AC);
    check(mg == AC + RC, "R8 waiting request after refresh", mg, AC + RC);
    repeat (10) cyc;
    check(ref_count == 15, "R9 held at max", int'(ref_count), 15);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule